// File: doc/BRIEF.md
# CAN Acceptance Filter with Single and Dual Layouts

This block decides whether a received CAN frame is kept. A receive path hands it an already parsed frame: identifier, extended flag, remote flag, data length code and the first two data bytes. Alongside the frame it gets eight configuration bytes, four acceptance code bytes and four acceptance mask bytes, and a layout select. It answers with one accept bit. A mask bit of 1 makes the matching code bit a don't-care.

In the single layout, one wide filter spans all eight bytes. For standard frames it also checks up to two data bytes. In the dual layout, the same bytes are split into two narrower filters, A and B, and a frame passes if either one hits. For standard frames, filter A also checks the first data byte. When the controller is not running its extended register set, the filter is bypassed and every frame is accepted. The decision is registered and appears one clock after the frame strobe.

Byte numbering: code byte k sits at `acc_code[8k+7:8k]` and mask byte k at `acc_mask[8k+7:8k]`, for k = 0..3. Mask byte k always qualifies code byte k bit for bit.

Top module: `can_accept_filter`

## Requirements
- R1: With `mode_en` = 0, every strobed frame is accepted, whatever the code, mask and frame contents.
- R2: Single layout, extended frame (`single_sel` = 1, `frm_ext` = 1). ID bits 28..21 compare with code byte 0, bits 20..13 with byte 1, bits 12..5 with byte 2, and bits 4..0 with byte 3 bits 7..3. The remote flag compares with byte 3 bit 2. A mismatch on any compared bit rejects the frame.
- R3: Single layout, standard frame. ID bits 10..3 compare with code byte 0 and ID bits 2..0 with byte 1 bits 7..5. The remote flag compares with byte 1 bit 4. A mismatch rejects the frame.
- R4: Single layout, standard frame with a matching ID. A remote frame is accepted, and so is a frame with DLC 0. Otherwise data byte 0 must equal code byte 2 under mask byte 2.
- R5: Single layout, standard frame with a matching ID and matching data byte 0. DLC 1 accepts. For DLC 2 or more (including codes above 8), data byte 1 must also equal code byte 3 under mask byte 3.
- R6: Dual layout, extended frame. Only ID bits 28..13 are compared. Filter A uses code bytes 0 and 1; filter B uses code bytes 2 and 3. The remote flag and ID bits 12..0 are ignored, and a hit on either filter accepts.
- R7: Dual layout, standard frame, filter A. The ID and remote flag compare with code bytes 0 and 1 as in R3. Data byte 0 must also equal {byte 1 bits 3..0, byte 3 bits 3..0}, masked by the same nibbles of the mask bytes. The data check applies even when DLC is 0.
- R8: Dual layout, standard frame, filter B. The ID compares with code byte 2 and byte 3 bits 7..5, and the remote flag with byte 3 bit 4. No data is checked. Either filter hitting accepts.
- R9: A mask byte set to all ones makes every bit it covers a don't-care. With all four mask bytes set, every frame is accepted.
- R10: `acc_valid` is high exactly in the cycle after a cycle with `frm_valid` high. `acc_ok` is low whenever `acc_valid` is low.
- R11: While `rst_n` is low, `acc_valid` and `acc_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | 1 = filtering active, 0 = accept everything |
| single_sel | input | 1 | 1 = single layout, 0 = dual layout |
| acc_code | input | 32 | Acceptance code bytes 0..3 |
| acc_mask | input | 32 | Acceptance mask bytes 0..3 (1 = don't care) |
| frm_valid | input | 1 | Frame strobe |
| frm_ext | input | 1 | 1 = 29-bit identifier |
| frm_rtr | input | 1 | Remote frame flag |
| frm_id | input | 29 | Identifier (standard frames use bits 10..0) |
| frm_dlc | input | 4 | Data length code |
| frm_data0 | input | 8 | First data byte |
| frm_data1 | input | 8 | Second data byte |
| acc_valid | output | 1 | Decision valid |
| acc_ok | output | 1 | Frame accepted |

## Verification
The bench builds the block with its default `OUT_REG` = 1. That puts the one-cycle strobe-to-decision timing and the reset values of the registered outputs within reach, and every vector is sampled in the cycle after its strobe. Both layouts are driven with extended and standard frames. The frame sets include single-bit ID and remote-flag mismatches, nibble-level data misses and DLC values of 0, 1, 2 and 8, each repeated with a mask bit set over the differing bit to show it turning into a don't-care.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
   localparam int BYTE_W     = 8;
   localparam int N_BYTES    = 4;
   localparam int CFG_W      = BYTE_W * N_BYTES;
   localparam int EXT_ID_W   = 29;
   localparam int STD_ID_W   = 11;
   localparam int DLC_W      = 4;
   localparam int DUAL_EXT_W = 2 * BYTE_W;
   localparam int NIB_W      = BYTE_W / 2;

   typedef logic [N_BYTES-1:0][BYTE_W-1:0] cfg_bytes_t;
endpackage

// File: rtl/can_af_mcmp.sv
module can_af_mcmp #(
   parameter int W = 8
) (
   input  logic [W-1:0] val,
   input  logic [W-1:0] ref_v,
   input  logic [W-1:0] dc,
   output logic         hit
);
   always_comb hit = &((val ~^ ref_v) | dc);
endmodule

// File: rtl/can_af_single.sv
module can_af_single
   import can_af_pkg::*;
(
   input  cfg_bytes_t             code,
   input  cfg_bytes_t             mask,
   input  logic                   ext,
   input  logic                   rtr,
   input  logic [EXT_ID_W-1:0]    id,
   input  logic [DLC_W-1:0]       dlc,
   input  logic [BYTE_W-1:0]      d0,
   input  logic [BYTE_W-1:0]      d1,
   output logic                   ok
);
   localparam int EXT_CW = EXT_ID_W + 1;
   localparam int STD_CW = STD_ID_W + 1;

   logic ext_hit, std_hit, d0_hit, d1_hit;
   logic unused_low_bits;

   assign unused_low_bits = ^{code[3][1:0], mask[3][1:0]};

   can_af_mcmp #(.W(EXT_CW)) u_ext (
      .val  ({id, rtr}),
      .ref_v({code[0], code[1], code[2], code[3][7:3], code[3][2]}),
      .dc   ({mask[0], mask[1], mask[2], mask[3][7:3], mask[3][2]}),
      .hit  (ext_hit));

   can_af_mcmp #(.W(STD_CW)) u_std (
      .val  ({id[STD_ID_W-1:0], rtr}),
      .ref_v({code[0], code[1][7:4]}),
      .dc   ({mask[0], mask[1][7:4]}),
      .hit  (std_hit));

   can_af_mcmp #(.W(BYTE_W)) u_d0 (
      .val(d0), .ref_v(code[2]), .dc(mask[2]), .hit(d0_hit));

   can_af_mcmp #(.W(BYTE_W)) u_d1 (
      .val(d1), .ref_v(code[3]), .dc(mask[3]), .hit(d1_hit));

   always_comb begin
      if (ext) ok = ext_hit;
      else     ok = std_hit && (rtr || (dlc == '0) ||
                                (d0_hit && ((dlc < DLC_W'(2)) || d1_hit)));
   end
endmodule

// File: rtl/can_af_dual.sv
module can_af_dual
   import can_af_pkg::*;
(
   input  cfg_bytes_t              code,
   input  cfg_bytes_t              mask,
   input  logic                    ext,
   input  logic                    rtr,
   input  logic [DUAL_EXT_W-1:0]   id_hi,
   input  logic [STD_ID_W-1:0]     id_std,
   input  logic [BYTE_W-1:0]       d0,
   output logic                    ok
);
   localparam int STD_CW = STD_ID_W + 1;
   localparam int NF     = 2;

   logic [NF-1:0] ext_hit;
   logic [NF-1:0] std_hit;

   for (genvar f = 0; f < NF; f++) begin : g_flt
      can_af_mcmp #(.W(DUAL_EXT_W)) u_ext (
         .val  (id_hi),
         .ref_v({code[2*f], code[2*f+1]}),
         .dc   ({mask[2*f], mask[2*f+1]}),
         .hit  (ext_hit[f]));

      if (f == 0) begin : g_with_data
         can_af_mcmp #(.W(STD_CW + BYTE_W)) u_std (
            .val  ({id_std, rtr, d0}),
            .ref_v({code[0], code[1][7:4], code[1][NIB_W-1:0], code[3][NIB_W-1:0]}),
            .dc   ({mask[0], mask[1][7:4], mask[1][NIB_W-1:0], mask[3][NIB_W-1:0]}),
            .hit  (std_hit[f]));
      end else begin : g_id_only
         can_af_mcmp #(.W(STD_CW)) u_std (
            .val  ({id_std, rtr}),
            .ref_v({code[2], code[3][7:4]}),
            .dc   ({mask[2], mask[3][7:4]}),
            .hit  (std_hit[f]));
      end
   end

   always_comb ok = ext ? |ext_hit : |std_hit;
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
   import can_af_pkg::*;
#(
   parameter int OUT_REG = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mode_en,
   input  logic                  single_sel,
   input  logic [CFG_W-1:0]      acc_code,
   input  logic [CFG_W-1:0]      acc_mask,
   input  logic                  frm_valid,
   input  logic                  frm_ext,
   input  logic                  frm_rtr,
   input  logic [EXT_ID_W-1:0]   frm_id,
   input  logic [DLC_W-1:0]      frm_dlc,
   input  logic [BYTE_W-1:0]     frm_data0,
   input  logic [BYTE_W-1:0]     frm_data1,
   output logic                  acc_valid,
   output logic                  acc_ok
);
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_out_reg
      $error("OUT_REG must be 0 or 1");
   end

   cfg_bytes_t code_b, mask_b;
   logic       single_ok, dual_ok, decide;

   assign code_b = acc_code;
   assign mask_b = acc_mask;

   can_af_single u_single (
      .code(code_b), .mask(mask_b), .ext(frm_ext), .rtr(frm_rtr),
      .id(frm_id), .dlc(frm_dlc), .d0(frm_data0), .d1(frm_data1),
      .ok(single_ok));

   can_af_dual u_dual (
      .code(code_b), .mask(mask_b), .ext(frm_ext), .rtr(frm_rtr),
      .id_hi(frm_id[EXT_ID_W-1 -: DUAL_EXT_W]),
      .id_std(frm_id[STD_ID_W-1:0]),
      .d0(frm_data0), .ok(dual_ok));

   always_comb decide = !mode_en || (single_sel ? single_ok : dual_ok);

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_valid <= 1'b0;
            acc_ok    <= 1'b0;
         end else begin
            acc_valid <= frm_valid;
            acc_ok    <= frm_valid && decide;
         end
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign acc_valid = frm_valid;
      assign acc_ok    = frm_valid && decide;
   end
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk
   import can_af_pkg::*;
#(
   parameter int OUT_REG = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_en,
   input logic [CFG_W-1:0] acc_mask,
   input logic             frm_valid,
   input logic             acc_valid,
   input logic             acc_ok
);
   if (OUT_REG == 1) begin : g_seq
      // R10: decision appears one cycle after the strobe, and only then
      assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
         frm_valid |=> acc_valid);
      assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !frm_valid |=> !acc_valid);
      // R1: bypass accepts everything
      assert_bypass_accepts_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (frm_valid && !mode_en) |=> acc_ok);
      // R9: all-ones mask accepts everything
      assert_full_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (frm_valid && mode_en && (&acc_mask)) |=> acc_ok);
   end
   // R10: no accept without a valid decision
   assert_ok_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !acc_ok);
endmodule

bind can_accept_filter can_accept_filter_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .acc_mask(acc_mask),
   .frm_valid(frm_valid), .acc_valid(acc_valid), .acc_ok(acc_ok));

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb_top;
   localparam int CLK_P = 10;
   localparam int NV    = 28;

   typedef struct packed {
      logic        en;
      logic        sgl;
      logic        ext;
      logic        rtr;
      logic [28:0] id;
      logic [3:0]  dlc;
      logic [7:0]  d0;
      logic [7:0]  d1;
      logic [31:0] code;   // {byte3, byte2, byte1, byte0}
      logic [31:0] mask;
      logic        exp;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VEC [NV] = '{
      // R1 bypass
      '{1'b0,1'b1,1'b1,1'b0,29'h0ABCDEF1,4'd2,8'h00,8'h00,32'h0,32'h0,1'b1,4'd1},
      // R2 single extended
      '{1'b1,1'b1,1'b1,1'b0,{8'hA5,8'h3C,8'h96,5'h15},4'd0,8'h00,8'h00,
        {5'h15,3'b000,8'h96,8'h3C,8'hA5},32'h0,1'b1,4'd2},
      '{1'b1,1'b1,1'b1,1'b0,{8'hA5,8'h3C,8'h96,5'h14},4'd0,8'h00,8'h00,
        {5'h15,3'b000,8'h96,8'h3C,8'hA5},32'h0,1'b0,4'd2},
      '{1'b1,1'b1,1'b1,1'b0,{8'hA5,8'h3C,8'h96,5'h14},4'd0,8'h00,8'h00,
        {5'h15,3'b000,8'h96,8'h3C,8'hA5},32'h08000000,1'b1,4'd2},
      '{1'b1,1'b1,1'b1,1'b1,{8'hA5,8'h3C,8'h96,5'h15},4'd0,8'h00,8'h00,
        {5'h15,3'b000,8'h96,8'h3C,8'hA5},32'h0,1'b0,4'd2},
      // R4 remote frame accepted after ID/RTR match (R3 layout)
      '{1'b1,1'b1,1'b0,1'b1,29'h5A3,4'd4,8'hFF,8'hFF,32'h000070B4,32'h0,1'b1,4'd4},
      // R3 ID mismatch
      '{1'b1,1'b1,1'b0,1'b0,29'h5A2,4'd0,8'h00,8'h00,32'h000060B4,32'h0,1'b0,4'd3},
      // R4 DLC 0
      '{1'b1,1'b1,1'b0,1'b0,29'h5A3,4'd0,8'h00,8'h00,32'h003360B4,32'h0,1'b1,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,29'h5A3,4'd3,8'h5A,8'h11,32'h115A60B4,32'h0,1'b1,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,29'h5A3,4'd1,8'h5B,8'h00,32'h005A60B4,32'h0,1'b0,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,29'h5A3,4'd1,8'h5B,8'h00,32'h005A60B4,32'h00010000,1'b1,4'd4},
      // R5 second data byte
      '{1'b1,1'b1,1'b0,1'b0,29'h5A3,4'd1,8'h5A,8'hFF,32'h005A60B4,32'h0,1'b1,4'd5},
      '{1'b1,1'b1,1'b0,1'b0,29'h5A3,4'd2,8'h5A,8'hFF,32'h005A60B4,32'h0,1'b0,4'd5},
      '{1'b1,1'b1,1'b0,1'b0,29'h5A3,4'd8,8'h5A,8'hFF,32'h005A60B4,32'hFF000000,1'b1,4'd5},
      // R6 dual extended
      '{1'b1,1'b0,1'b1,1'b1,{8'hC3,8'h81,13'h1ABC},4'd0,8'h00,8'h00,32'h000081C3,32'h0,1'b1,4'd6},
      '{1'b1,1'b0,1'b1,1'b0,{8'hC3,8'h81,13'h1ABC},4'd0,8'h00,8'h00,32'h81C381C2,32'h0,1'b1,4'd6},
      '{1'b1,1'b0,1'b1,1'b0,{8'hC3,8'h81,13'h1ABC},4'd0,8'h00,8'h00,32'h80C381C2,32'h0,1'b0,4'd6},
      '{1'b1,1'b0,1'b1,1'b0,{8'hC3,8'h81,13'h1ABC},4'd0,8'h00,8'h00,32'h80C381C2,32'h01000000,1'b1,4'd6},
      // R7 dual standard filter A with data nibbles
      '{1'b1,1'b0,1'b0,1'b0,29'h5A3,4'd1,8'h9E,8'h00,32'h0E0069B4,32'h0,1'b1,4'd7},
      '{1'b1,1'b0,1'b0,1'b0,29'h5A3,4'd1,8'h9F,8'h00,32'h0E0069B4,32'h0,1'b0,4'd7},
      '{1'b1,1'b0,1'b0,1'b0,29'h5A3,4'd1,8'h9F,8'h00,32'h0E0069B4,32'h01000000,1'b1,4'd7},
      '{1'b1,1'b0,1'b0,1'b0,29'h5A3,4'd0,8'h9F,8'h00,32'h0E0069B4,32'h0,1'b0,4'd7},
      // R8 dual standard filter B
      '{1'b1,1'b0,1'b0,1'b0,29'h5A3,4'd1,8'h00,8'h00,32'h6EB46900,32'h0,1'b1,4'd8},
      '{1'b1,1'b0,1'b0,1'b1,29'h5A3,4'd1,8'h00,8'h00,32'h6EB46900,32'h0,1'b0,4'd8},
      '{1'b1,1'b0,1'b0,1'b1,29'h5A3,4'd1,8'h00,8'h00,32'h6EB46900,32'h10000000,1'b1,4'd8},
      // R9 all-ones mask
      '{1'b1,1'b1,1'b0,1'b0,29'h7FF,4'd8,8'hFF,8'hFF,32'h0,32'hFFFFFFFF,1'b1,4'd9},
      '{1'b1,1'b0,1'b1,1'b1,29'h1FFFFFFF,4'd0,8'h00,8'h00,32'h0,32'hFFFFFFFF,1'b1,4'd9},
      // R1 bypass with a standard frame that would fail
      '{1'b0,1'b1,1'b0,1'b0,29'h5A2,4'd2,8'h12,8'h34,32'h005A60B4,32'h0,1'b1,4'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_en = 1'b0, single_sel = 1'b0;
   logic [31:0] acc_code = '0, acc_mask = '0;
   logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
   logic [28:0] frm_id = '0;
   logic [3:0]  frm_dlc = '0;
   logic [7:0]  frm_data0 = '0, frm_data1 = '0;
   logic        acc_valid, acc_ok;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   can_accept_filter dut_i (
      .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .single_sel(single_sel),
      .acc_code(acc_code), .acc_mask(acc_mask), .frm_valid(frm_valid),
      .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_id(frm_id), .frm_dlc(frm_dlc),
      .frm_data0(frm_data0), .frm_data1(frm_data1),
      .acc_valid(acc_valid), .acc_ok(acc_ok));

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      mode_en = v.en; single_sel = v.sgl; frm_ext = v.ext; frm_rtr = v.rtr;
      frm_id = v.id; frm_dlc = v.dlc; frm_data0 = v.d0; frm_data1 = v.d1;
      acc_code = v.code; acc_mask = v.mask;
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R11 reset state
      repeat (3) @(negedge clk);
      frm_valid = 1'b1;
      @(negedge clk);
      chk("R11", "acc_valid in reset", acc_valid, 1'b0);
      chk("R11", "acc_ok in reset", acc_ok, 1'b0);
      frm_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         frm_valid = 1'b1;
         @(negedge clk);
         frm_valid = 1'b0;
         chk($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d valid", i), acc_valid, 1'b1);
         chk($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d accept", i), acc_ok, VEC[i].exp);
      end

      // R10: no strobe, no decision, even with a matching frame presented
      drive(VEC[1]);
      @(negedge clk);
      chk("R10", "valid without strobe", acc_valid, 1'b0);
      chk("R10", "ok without strobe", acc_ok, 1'b0);

      // R10: back-to-back strobes give back-to-back decisions
      drive(VEC[2]);
      frm_valid = 1'b1;
      @(negedge clk);
      chk("R10", "b2b first valid", acc_valid, 1'b1);
      chk("R10", "b2b first reject", acc_ok, 1'b0);
      drive(VEC[1]);
      @(negedge clk);
      frm_valid = 1'b0;
      chk("R10", "b2b second accept", acc_ok, 1'b1);
      @(negedge clk);
      chk("R10", "valid drops after strobe", acc_valid, 1'b0);

      // R11: reset in mid-stream clears outputs
      frm_valid = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R11", "async reset clears valid", acc_valid, 1'b0);
      chk("R11", "async reset clears ok", acc_ok, 1'b0);
      frm_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule